// File: doc/BRIEF.md
# Transmit Buffer Request Tracker

This block holds one pending-transmission flag per transmit message buffer of a CAN FD controller whose frames live in a message RAM. The host raises flags through a write port. A single write can raise any number of them. Writing a zero never lowers a flag. Flags are lowered only by the controller: either when the frame in that buffer has gone out, or when an abort of that buffer has succeeded. The transmit scheduler reads the whole pending mask. The host reads a saturation flag and a pending count. When the mask is saturated, no further request can be placed until a completion or an abort frees a buffer.

Each buffer also keeps an event-logging flag. This flag is captured from one bit of the length-code word when the host writes that word for the buffer. When a pending buffer that carries this flag completes, the block emits a one-cycle strobe that carries the buffer's index. An event FIFO downstream uses it.

Top module: `txreq_tracker`

## Requirements
- R1: After reset, `pend_mask` is all zero, `all_full` is 0, `pend_cnt` is 0 and `log_vld` is 0.
- R2: A cycle with `host_wr_en` high sets, at the next clock edge, every `pend_mask` bit whose `host_wr_data` bit is 1. Several bits can be set in one write.
- R3: A `host_wr_data` bit of 0 leaves the matching `pend_mask` bit unchanged, whether that bit is set or clear.
- R4: A cycle with `done_vld` high clears, at the next edge, only the `pend_mask` bit selected by the one-hot `done_onehot`.
- R5: A cycle with `cancel_vld` high clears, at the next edge, only the `pend_mask` bit selected by the one-hot `cancel_onehot`.
- R6: If a host set and a completion or abort clear target the same bit in the same cycle, the bit is 0 after the edge.
- R7: `all_full` is 1 exactly when every `pend_mask` bit is 1. `pend_cnt` equals the number of set `pend_mask` bits. Both follow the mask in the same cycle.
- R8: A cycle with `dlc_wr_en` high stores bit `EVT_POS` (default 5) of `dlc_wr_word` as the logging flag of buffer `dlc_wr_idx`. If a buffer is pending and flagged, its completion produces `log_vld` = 1 for exactly the one cycle after that edge, with `log_idx` set to the buffer number.
- R9: A completion of a buffer whose logging flag is 0, or whose request bit is not pending, produces no `log_vld`. An abort never produces one.
- R10: A completion and an abort of different buffers in the same cycle clear both bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for request bits |
| host_wr_data | input | NUM_BUF | Bits to set (1 = request) |
| dlc_wr_en | input | 1 | Host wrote a buffer's length-code word |
| dlc_wr_idx | input | IDX_W | Buffer that the length-code word belongs to |
| dlc_wr_word | input | DLC_W | Length-code word; bit EVT_POS is the logging flag |
| done_vld | input | 1 | Transmission completed |
| done_onehot | input | NUM_BUF | One-hot completed buffer |
| cancel_vld | input | 1 | Abort succeeded |
| cancel_onehot | input | NUM_BUF | One-hot aborted buffer |
| pend_mask | output | NUM_BUF | Pending request bits |
| all_full | output | 1 | Every buffer pending |
| pend_cnt | output | CNT_W | Number of pending buffers |
| log_vld | output | 1 | Event-log strobe |
| log_idx | output | IDX_W | Buffer of the logged completion |

## Verification
The bench writes masks that mix ones and zeros over bits that are already set. A design that treated the write as a plain load would drop the older requests. It drives a host set and a completion onto the same bit in one cycle. A design that gave priority to the host would leave a stale request that would be transmitted twice. It fills every buffer to check saturation and the count, and clears two bits in one cycle by completion and abort together. It fires completions on a flagged buffer, an unflagged buffer and a buffer that is not pending. A design that logged regardless of state would push false events, or would hold the strobe for more than one cycle.

// File: rtl/txreq_pkg.sv
package txreq_pkg;

   localparam int unsigned MAX_BUF = 256;

   // Index of the lowest set bit; zero when the vector is empty.
   function automatic logic [7:0] low_index(input logic [MAX_BUF-1:0] vec);
      logic [7:0] idx;
      idx = '0;
      for (int i = MAX_BUF - 1; i >= 0; i--) begin
         if (vec[i]) idx = 8'(i);
      end
      return idx;
   endfunction

endpackage

// File: rtl/txreq_bit_cell.sv
module txreq_bit_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic done_i,
   input  logic flag_we_i,
   input  logic flag_d_i,
   output logic req_o,
   output logic log_hit_o
);

   logic evt_q;

   // A hardware clear takes precedence over a host set.
   always_ff @(posedge clk) begin
      if (!rst_n)      req_o <= 1'b0;
      else if (clr_i)  req_o <= 1'b0;
      else if (set_i)  req_o <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         evt_q <= 1'b0;
      else if (flag_we_i) evt_q <= flag_d_i;
   end

   assign log_hit_o = done_i & req_o & evt_q;

endmodule

// File: rtl/txreq_popcount.sv
module txreq_popcount #(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned CW   = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic [CW-1:0]    cnt_o
);

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < WIDTH; i++) begin
         cnt_o = cnt_o + CW'(vec_i[i]);
      end
   end

endmodule

// File: rtl/txreq_log_strobe.sv
module txreq_log_strobe #(
   parameter int unsigned NUM_BUF = 8,
   localparam int unsigned IDX_W  = $clog2(NUM_BUF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_BUF-1:0] hit_i,
   output logic               vld_o,
   output logic [IDX_W-1:0]   idx_o
);
   import txreq_pkg::*;

   logic [MAX_BUF-1:0] hit_wide;
   logic [7:0]         enc;

   assign hit_wide = MAX_BUF'(hit_i);
   assign enc      = low_index(hit_wide);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         idx_o <= '0;
      end else begin
         vld_o <= |hit_i;
         idx_o <= IDX_W'(enc);
      end
   end

endmodule

// File: rtl/txreq_tracker.sv
module txreq_tracker #(
   parameter int unsigned NUM_BUF    = 8,
   parameter int unsigned DLC_W      = 8,
   parameter int unsigned EVT_POS    = 5,
   parameter bit          LOG_ENABLE = 1'b1,
   localparam int unsigned IDX_W     = $clog2(NUM_BUF),
   localparam int unsigned CNT_W     = $clog2(NUM_BUF + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr_en,
   input  logic [NUM_BUF-1:0] host_wr_data,
   input  logic               dlc_wr_en,
   input  logic [IDX_W-1:0]   dlc_wr_idx,
   input  logic [DLC_W-1:0]   dlc_wr_word,
   input  logic               done_vld,
   input  logic [NUM_BUF-1:0] done_onehot,
   input  logic               cancel_vld,
   input  logic [NUM_BUF-1:0] cancel_onehot,
   output logic [NUM_BUF-1:0] pend_mask,
   output logic               all_full,
   output logic [CNT_W-1:0]   pend_cnt,
   output logic               log_vld,
   output logic [IDX_W-1:0]   log_idx
);

   // Elaboration-time parameter checks
   if (NUM_BUF < 2 || NUM_BUF > txreq_pkg::MAX_BUF) begin : g_bad_num
      $error("txreq_tracker: NUM_BUF out of range");
   end
   if (EVT_POS >= DLC_W) begin : g_bad_pos
      $error("txreq_tracker: EVT_POS outside length-code word");
   end

   logic [NUM_BUF-1:0] set_vec;
   logic [NUM_BUF-1:0] done_vec;
   logic [NUM_BUF-1:0] clr_vec;
   logic [NUM_BUF-1:0] hit_vec;

   assign set_vec  = host_wr_en ? host_wr_data  : '0;
   assign done_vec = done_vld   ? done_onehot   : '0;
   assign clr_vec  = done_vec | (cancel_vld ? cancel_onehot : '0);

   for (genvar b = 0; b < NUM_BUF; b++) begin : g_cell
      logic flag_we;
      assign flag_we = LOG_ENABLE && dlc_wr_en && (dlc_wr_idx == IDX_W'(b));
      txreq_bit_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_i     (set_vec[b]),
         .clr_i     (clr_vec[b]),
         .done_i    (done_vec[b]),
         .flag_we_i (flag_we),
         .flag_d_i  (dlc_wr_word[EVT_POS]),
         .req_o     (pend_mask[b]),
         .log_hit_o (hit_vec[b])
      );
   end

   txreq_popcount #(.WIDTH(NUM_BUF)) u_cnt (
      .vec_i (pend_mask),
      .cnt_o (pend_cnt)
   );

   assign all_full = &pend_mask;

   if (LOG_ENABLE) begin : g_log
      txreq_log_strobe #(.NUM_BUF(NUM_BUF)) u_log (
         .clk   (clk),
         .rst_n (rst_n),
         .hit_i (hit_vec),
         .vld_o (log_vld),
         .idx_o (log_idx)
      );
   end else begin : g_nolog
      logic unused_hits;
      assign unused_hits = |hit_vec;
      assign log_vld = 1'b0;
      assign log_idx = '0;
   end

endmodule

// File: rtl/txreq_tracker_chk.sv
module txreq_tracker_chk #(
   parameter int unsigned NUM_BUF = 8,
   parameter int unsigned IDX_W   = 3,
   parameter int unsigned CNT_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               host_wr_en,
   input logic [NUM_BUF-1:0] host_wr_data,
   input logic               done_vld,
   input logic [NUM_BUF-1:0] done_onehot,
   input logic               cancel_vld,
   input logic [NUM_BUF-1:0] cancel_onehot,
   input logic [NUM_BUF-1:0] pend_mask,
   input logic               all_full,
   input logic [CNT_W-1:0]   pend_cnt,
   input logic               log_vld,
   input logic [IDX_W-1:0]   log_idx
);

   logic [NUM_BUF-1:0] c_clr;
   logic [NUM_BUF-1:0] c_set;
   logic [NUM_BUF-1:0] c_done;
   assign c_done = done_vld ? done_onehot : '0;
   assign c_clr  = c_done | (cancel_vld ? cancel_onehot : '0);
   assign c_set  = host_wr_en ? host_wr_data : '0;

   // R2: every requested bit not being cleared is set after the edge
   a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_mask & $past(c_set & ~c_clr)) == $past(c_set & ~c_clr)));

   // R3: bits fall only where a clear was presented
   a_r3_no_spurious_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend_mask) & ~pend_mask & ~$past(c_clr)) == '0));

   // R4 / R6: completed bit is clear after the edge, even if also set
   a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      done_vld |=> ((pend_mask & $past(done_onehot)) == '0));

   // R5: aborted bit is clear after the edge
   a_r5_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_vld |=> ((pend_mask & $past(cancel_onehot)) == '0));

   // R7: saturation flag agrees with the count
   a_r7_full_vs_count: assert property (@(posedge clk) disable iff (!rst_n)
      all_full == (pend_cnt == CNT_W'(NUM_BUF)));

   // R8: a strobe follows a completion of a pending buffer with that index
   a_r8_log_source: assert property (@(posedge clk) disable iff (!rst_n)
      log_vld |-> ($past(done_vld) && $past(done_onehot & pend_mask) != '0
                   && (($past(done_onehot) >> log_idx) & NUM_BUF'(1)) != '0));

   // R9: nothing is logged without a completion
   a_r9_no_log_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(done_vld) |-> !log_vld);

endmodule

bind txreq_tracker txreq_tracker_chk #(
   .NUM_BUF (NUM_BUF),
   .IDX_W   (IDX_W),
   .CNT_W   (CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_wr_en    (host_wr_en),
   .host_wr_data  (host_wr_data),
   .done_vld      (done_vld),
   .done_onehot   (done_onehot),
   .cancel_vld    (cancel_vld),
   .cancel_onehot (cancel_onehot),
   .pend_mask     (pend_mask),
   .all_full      (all_full),
   .pend_cnt      (pend_cnt),
   .log_vld       (log_vld),
   .log_idx       (log_idx)
);

// File: tb/txreq_tracker_test.sv
module txreq_tracker_test;

   localparam int CLK_PERIOD = 10;
   localparam int NB  = 8;
   localparam int IW  = 3;
   localparam int CW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_wr_en = 1'b0;
   logic [NB-1:0] host_wr_data = '0;
   logic          dlc_wr_en = 1'b0;
   logic [IW-1:0] dlc_wr_idx = '0;
   logic [7:0]    dlc_wr_word = '0;
   logic          done_vld = 1'b0;
   logic [NB-1:0] done_onehot = '0;
   logic          cancel_vld = 1'b0;
   logic [NB-1:0] cancel_onehot = '0;
   logic [NB-1:0] pend_mask;
   logic          all_full;
   logic [CW-1:0] pend_cnt;
   logic          log_vld;
   logic [IW-1:0] log_idx;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txreq_tracker uut (
      .clk(clk), .rst_n(rst_n),
      .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .dlc_wr_en(dlc_wr_en), .dlc_wr_idx(dlc_wr_idx), .dlc_wr_word(dlc_wr_word),
      .done_vld(done_vld), .done_onehot(done_onehot),
      .cancel_vld(cancel_vld), .cancel_onehot(cancel_onehot),
      .pend_mask(pend_mask), .all_full(all_full), .pend_cnt(pend_cnt),
      .log_vld(log_vld), .log_idx(log_idx)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // Present inputs for one edge, then drop them and settle past the edge.
   task automatic step();
      @(posedge clk);
      #1;
      host_wr_en = 0; host_wr_data = '0;
      dlc_wr_en  = 0; dlc_wr_word  = '0;
      done_vld   = 0; done_onehot  = '0;
      cancel_vld = 0; cancel_onehot = '0;
   endtask

   task automatic t_reset();
      check("R1 mask", pend_mask, 0);
      check("R1 full", all_full, 0);
      check("R1 cnt", pend_cnt, 0);
      check("R1 log", log_vld, 0);
   endtask

   task automatic t_multi_set();
      host_wr_en = 1; host_wr_data = 8'hA5;
      step();
      check("R2 multi-bit set", pend_mask, 8'hA5);
      check("R7 count", pend_cnt, 4);
      check("R7 not full", all_full, 0);
   endtask

   task automatic t_zero_write();
      host_wr_en = 1; host_wr_data = 8'h02;
      step();
      check("R3 zeros keep bits", pend_mask, 8'hA7);
   endtask

   task automatic t_done();
      done_vld = 1; done_onehot = 8'h04;
      step();
      check("R4 done clears one bit", pend_mask, 8'hA3);
      check("R9 unflagged no log", log_vld, 0);
   endtask

   task automatic t_cancel();
      cancel_vld = 1; cancel_onehot = 8'h80;
      step();
      check("R5 cancel clears one bit", pend_mask, 8'h23);
      check("R9 cancel no log", log_vld, 0);
   endtask

   task automatic t_full();
      host_wr_en = 1; host_wr_data = 8'hFF;
      step();
      check("R7 full flag", all_full, 1);
      check("R7 full count", pend_cnt, 8);
   endtask

   task automatic t_conflict();
      host_wr_en = 1; host_wr_data = 8'h08;
      done_vld = 1; done_onehot = 8'h08;
      step();
      check("R6 clear beats set", pend_mask, 8'hF7);
      check("R7 full drops", all_full, 0);
      done_vld = 1; done_onehot = 8'h02;
      cancel_vld = 1; cancel_onehot = 8'h01;
      step();
      check("R10 done+cancel both clear", pend_mask, 8'hF4);
      check("R10 count", pend_cnt, 5);
   endtask

   task automatic t_log();
      dlc_wr_en = 1; dlc_wr_idx = 3'd4; dlc_wr_word = 8'h28;
      step();
      done_vld = 1; done_onehot = 8'h10;
      step();
      check("R8 strobe", log_vld, 1);
      check("R8 index", log_idx, 4);
      check("R8 mask", pend_mask, 8'hE4);
      @(posedge clk); #1;
      check("R8 single cycle", log_vld, 0);
   endtask

   task automatic t_nolog();
      done_vld = 1; done_onehot = 8'h10;
      step();
      check("R9 not pending no log", log_vld, 0);
      dlc_wr_en = 1; dlc_wr_idx = 3'd6; dlc_wr_word = 8'h1F;
      step();
      done_vld = 1; done_onehot = 8'h40;
      step();
      check("R9 flag clear no log", log_vld, 0);
      check("R4 mask after done", pend_mask, 8'hA4);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      t_reset();
      t_multi_set();
      t_zero_write();
      t_done();
      t_cancel();
      t_full();
      t_conflict();
      t_log();
      t_nolog();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog act=hung exp=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule